// File: doc/BRIEF.md
# Fixed-Size Flit Packer

This block turns a byte-wide stream of variable-length transaction packets into an unbroken stream of fixed 256-byte flits. Each flit opens with a two-byte header. The header holds a running flit sequence number and a flag that says whether the flit opens in the middle of a packet. The other 254 byte slots carry packet bytes back to back. A flit may therefore hold several short packets, all or part of one long packet, or the tail of one packet followed by the head of the next. Packet edges and flit edges are independent of each other. No CRC, framing token or clock-compensation symbol is added for each packet.

The output never stalls. A byte leaves on every cycle after reset. When a payload slot comes up and the upstream source has nothing valid, the slot is filled with 0x00 and marked idle on a sideband flag. The upstream source uses a valid/ready handshake and sees ready drop only while the two header bytes go out.

A three-state controller sequences each flit. ST_SEQ emits the sequence byte and always moves to ST_FLAG. ST_FLAG emits the flag byte and always moves to ST_BODY. ST_BODY emits 254 payload slots and returns to ST_SEQ after the last one. Reset enters ST_SEQ. Outputs are registered, so a byte chosen in a given cycle appears on the output one cycle later.

Top module: `flit_packer`

## Requirements
- R1: After reset, out_valid stays high on every cycle. out_sof is high on byte 0 of each flit only, and consecutive out_sof pulses are exactly 256 cycles apart.
- R2: Header byte 0 is the flit sequence number. The first flit after reset carries 0, and each later flit carries the previous value plus one, modulo 256. Header bytes are never marked idle.
- R3: In header byte 1, bit 0 is the continuation flag and bits 7:1 are zero.
- R4: in_ready is low while the two header bytes are being chosen, and during reset. It is high for every payload slot, so a byte is accepted only on a cycle with in_valid and in_ready both high.
- R5: Accepted bytes appear in payload slots in acceptance order, with no loss, duplication or inserted framing or check bytes. Packets are packed with no gap beyond the idle slots caused by missing input.
- R6: The continuation flag is 1 exactly when a packet's start has been accepted and its end has not yet been accepted by the time the header is emitted. Such a packet resumes in the next payload slot without restarting.
- R7: A payload slot with no byte accepted carries 0x00 with out_idle high. out_idle is low for every slot that carries packet data.
- R8: Packets of any length from 12 to 4112 bytes are carried intact, including ones that span many flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Packer can take a byte this cycle |
| in_data | input | 8 | Input packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| out_valid | output | 1 | Output byte present (high from the first cycle after reset) |
| out_data | output | 8 | Flit byte |
| out_sof | output | 1 | Byte 0 of a flit |
| out_idle | output | 1 | Payload slot filled with 0x00 |

## Verification
Two things can land on the same cycle. The first is a valid input byte from a source that is holding its data, arriving while the controller is emitting header bytes. The bench keeps in_valid high across flit boundaries with long and back-to-back packets. It then checks that the held byte appears in the first payload slot and is neither lost nor duplicated. The second is a packet end that lands on the last slot of a flit, which must clear the continuation flag of the next header. A reference model rebuilt from the output stream predicts that flag for every header, whichever of the two ways the boundary falls.

// File: rtl/flit_pkg.sv
package flit_pkg;
    typedef enum logic [1:0] {
        ST_SEQ  = 2'd0,
        ST_FLAG = 2'd1,
        ST_BODY = 2'd2
    } flit_state_e;
endpackage

// File: rtl/flit_seq_fsm.sv
module flit_seq_fsm
    import flit_pkg::*;
#(
    parameter int FLIT_BYTES = 256,
    parameter int HDR_BYTES  = 2,
    parameter int SEQ_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output flit_state_e      state,
    output logic [SEQ_W-1:0] seq,
    output logic             take_ok
);
    localparam int PAY_BYTES = FLIT_BYTES - HDR_BYTES;
    localparam int CNT_W     = $clog2(PAY_BYTES);

    flit_state_e      state_q, state_d;
    logic [CNT_W-1:0] body_cnt;
    logic [SEQ_W-1:0] seq_q;
    logic             last_slot;

    assign last_slot = (body_cnt == CNT_W'(PAY_BYTES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:  state_d = ST_FLAG;
            ST_FLAG: state_d = ST_BODY;
            ST_BODY: if (last_slot) state_d = ST_SEQ;
            default: state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SEQ;
            body_cnt <= '0;
            seq_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BODY)
                body_cnt <= last_slot ? '0 : body_cnt + 1'b1;
            if (state_q == ST_SEQ)
                seq_q <= seq_q + 1'b1;
        end
    end

    always_comb begin
        state   = state_q;
        seq     = seq_q;
        take_ok = (state_q == ST_BODY);
    end

    assert_cnt_idle_hdr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BODY) |-> (body_cnt == '0));
endmodule

// File: rtl/flit_pkt_track.sv
module flit_pkt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic in_sop,
    input  logic in_eop,
    output logic pkt_open
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (take) begin
            if (in_eop)      open_q <= 1'b0;
            else if (in_sop) open_q <= 1'b1;
        end
    end

    assign pkt_open = open_q;

    assert_open_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(open_q));
endmodule

// File: rtl/flit_byte_mux.sv
module flit_byte_mux
    import flit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flit_state_e       state,
    input  logic [DATA_W-1:0] seq,
    input  logic              pkt_open,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_idle
);
    logic [DATA_W-1:0] byte_d;
    logic              sof_d, idle_d;

    always_comb begin
        byte_d = '0;
        sof_d  = 1'b0;
        idle_d = 1'b0;
        unique case (state)
            ST_SEQ: begin
                byte_d = seq;
                sof_d  = 1'b1;
            end
            ST_FLAG: byte_d = {{(DATA_W-1){1'b0}}, pkt_open};
            ST_BODY: begin
                byte_d = take ? in_data : '0;
                idle_d = !take;
            end
            default: byte_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_idle  <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            out_data  <= byte_d;
            out_sof   <= sof_d;
            out_idle  <= idle_d;
        end
    end

    // checking state for header properties
    logic [DATA_W-1:0] last_seq;
    logic              have_seq, prev_sof;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_seq <= '0;
            have_seq <= 1'b0;
            prev_sof <= 1'b0;
        end else begin
            prev_sof <= out_sof;
            if (out_sof) begin
                last_seq <= out_data;
                have_seq <= 1'b1;
            end
        end
    end

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && have_seq) |-> (out_data == last_seq + 1'b1));
    assert_first_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && !have_seq) |-> (out_data == '0));
    assert_flag_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_sof |-> (out_data[DATA_W-1:1] == '0 && !out_idle));
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_idle |-> (out_data == '0 && !out_sof));
endmodule

// File: rtl/flit_packer.sv
module flit_packer
    import flit_pkg::*;
#(
    parameter int FLIT_BYTES = 256,
    parameter int HDR_BYTES  = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_idle
);
    localparam int GAP_W = $clog2(FLIT_BYTES) + 1;

    flit_state_e       state;
    logic [DATA_W-1:0] seq;
    logic              take_ok, take, pkt_open;

    flit_seq_fsm #(
        .FLIT_BYTES(FLIT_BYTES),
        .HDR_BYTES (HDR_BYTES),
        .SEQ_W     (DATA_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .seq    (seq),
        .take_ok(take_ok)
    );

    assign in_ready = take_ok;
    assign take     = in_valid && take_ok;

    flit_pkt_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .in_sop  (in_sop),
        .in_eop  (in_eop),
        .pkt_open(pkt_open)
    );

    flit_byte_mux #(.DATA_W(DATA_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .seq      (seq),
        .pkt_open (pkt_open),
        .take     (take),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_sof  (out_sof),
        .out_idle (out_idle)
    );

    // flit period checker
    logic [GAP_W-1:0] gap_cnt;
    logic             seen_sof;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            seen_sof <= 1'b0;
        end else if (out_sof) begin
            gap_cnt  <= '0;
            seen_sof <= 1'b1;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_sof_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && seen_sof) |-> (gap_cnt == GAP_W'(FLIT_BYTES - 1)));
    assert_no_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
    assert_ready_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (out_valid && !out_sof));
endmodule

// File: tb/flit_packer_bench.sv
module flit_packer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       out_valid, out_sof, out_idle;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    flit_packer u_flit_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_idle(out_idle)
    );

    // stimulus vectors: packet length, idle cycles after, expected flits spanned at least
    localparam int NV = 12;
    localparam int V_LEN [NV] = '{12, 12, 12, 40, 254, 300, 4112, 12, 100, 253, 12, 500};
    localparam int V_GAP [NV] = '{0, 0, 3, 0, 10, 0, 0, 300, 0, 0, 1, 0};
    localparam int V_MINF[NV] = '{1, 1, 1, 1, 1, 2, 17, 1, 1, 1, 1, 2};

    int errors = 0;
    int checks = 0;
    logic [9:0] exp_q[$];
    int  pos = 0;
    logic [7:0] exp_seq = '0;
    bit  open = 0;
    bit  seen = 0;
    int  flits_seen = 0;
    int  cont_seen = 0;
    bit  done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference monitor rebuilt from output stream
    always @(negedge clk) begin
        if (!rst_n) begin
            pos = 0; exp_seq = '0; open = 0; seen = 0;
        end else begin
            if (seen) chk(out_valid, "R1 continuous", out_valid, 1);
            if (out_valid) begin
                if (out_sof) begin
                    if (seen) chk(pos == 255, "R1 flit length", pos + 1, 256);
                    pos = 0;
                    flits_seen++;
                end else begin
                    pos = pos + 1;
                    chk(pos <= 255, "R1 sof missing", pos, 255);
                end
                seen = 1;
                chk(in_ready == !(pos == 255 || pos == 0), "R4 ready vs slot",
                    in_ready, !(pos == 255 || pos == 0));
                if (pos == 0) begin
                    chk(out_data == exp_seq && !out_idle, "R2 seq byte", out_data, exp_seq);
                    exp_seq = exp_seq + 1'b1;
                end else if (pos == 1) begin
                    chk(out_data[7:1] == 0 && !out_idle, "R3 reserved", out_data, {7'd0, open});
                    chk(out_data[0] == open, "R6 cont flag", out_data[0], open);
                    if (open) cont_seen++;
                end else if (out_idle) begin
                    chk(out_data == 8'h00, "R7 idle byte", out_data, 0);
                end else begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R5 extra byte", out_data, 0);
                    end else begin
                        logic [9:0] e;
                        e = exp_q.pop_front();
                        chk(out_data == e[7:0], "R5 payload order", out_data, e[7:0]);
                        if (e[8]) open = 0;
                        else if (e[9]) open = 1;
                    end
                end
            end
        end
    end

    task automatic send_pkt(input int idx, input int len);
        for (int b = 0; b < len; b++) begin
            bit hs;
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'((idx * 37 + b * 5 + 1) & 8'hff);
            in_sop   = (b == 0);
            in_eop   = (b == len - 1);
            hs = in_ready;
            @(posedge clk);
            while (!hs) begin
                @(negedge clk);
                hs = in_ready;
                @(posedge clk);
            end
            exp_q.push_back({in_sop, in_eop, in_data});
        end
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !in_ready && !out_sof, "R4 reset outputs", {out_valid, in_ready, out_sof}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid && out_sof && out_data == 8'h00, "R2 first seq zero", out_data, 0);

        for (int v = 0; v < NV; v++) begin
            int f0;
            f0 = flits_seen;
            send_pkt(v, V_LEN[v]);
            if (V_GAP[v] > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (V_GAP[v] - 1) @(negedge clk);
            end
            if (V_LEN[v] > 254)
                chk(flits_seen - f0 >= V_MINF[v] - 1, "R8 long packet span", flits_seen - f0, V_MINF[v] - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (600) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
        chk(cont_seen >= 17, "R6 continuation flits", cont_seen, 17);
        chk(!open, "R6 no open packet at end", open, 0);

        // mid-run reset restarts sequence
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!out_valid && !in_ready, "R4 reset mid-run", {out_valid, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_sof && out_data == 8'h00, "R2 seq restarts", out_data, 0);
        @(negedge clk);
        chk(out_data == 8'h00, "R3 flag cleared by reset", out_data, 0);
        @(negedge clk);
        chk(out_idle && out_data == 8'h00, "R7 idle with no input", out_data, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule